// File: doc/BRIEF.md
# Reversible Shift-Add Multiplier Sequencer

This block forms the product of two unsigned N-bit operands. It models a reversible computation on a classical bit register that is 4N+1 bits wide. The register holds the multiplicand A (N bits), the multiplier B (N bits) and a product field P (2N+1 bits) that is cleared before each run. Every step either flips a target bit under the AND of two control bits or performs a controlled in-place addition. A therefore leaves the run unchanged, B leaves it unchanged, and the top bit of P returns to zero.

A run has two phases. The lowest partial product needs no addition, so a row of N controlled-controlled flips writes a[i]·b[0] into p[i]. After that, one controlled-adder pass runs for each multiplier bit b[j], with j going from 1 to N-1. Pass j adds A into the window p[j..j+N-1]. It uses p[j+N] as the location that receives the carry-out and p[j+N+1] as a scratch bit that ends at zero. The sequencer also keeps a weighted gate-cost total. The flip row adds 7·N to it, and each adder pass adds 21·N+14.

Top module: `rev_mul_seq`

## Requirements
- R1: While reset is asserted and just after it, done_o is 0, prod_o is 0, spare_o is 0 and cost_o is 0.
- R2: A start_i pulse sampled while the block is idle or finished loads op_a_i and op_b_i, clears the whole product field and clears the cost total.
- R3: One clock edge after start is sampled, prod_o shows p[i] = a[i] AND b[0] for i < N, its upper N bits are 0, and cost_o equals 7·N.
- R4: done_o first reads 1 on the 2N-1-th clock edge after the edge that samples start_i.
- R5: When done_o is 1, prod_o (bits p[0..2N-1]) equals the unsigned product of the loaded operands.
- R6: When done_o is 1, spare_o (bit p[2N]) is 0.
- R7: op_a_o and op_b_o show the loaded operands and do not change between load and the next start, so the final register still holds A and B.
- R8: When done_o is 1, cost_o equals 21·N²−14.
- R9: Adder passes run strictly one after another. A pass starts only when no pass is in flight. The pass index stays between 1 and N-1, so the top scratch location of the last pass is exactly p[2N].
- R10: start_i has no effect while a run is in progress. When done_o is 1 it stays 1, and prod_o does not change, until a new start_i arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the operands and begin a run |
| op_a_i | input | N | Multiplicand loaded at start |
| op_b_i | input | N | Multiplier loaded at start |
| done_o | output | 1 | Run finished, result valid |
| prod_o | output | 2N | Product field bits p[0..2N-1] |
| spare_o | output | 1 | Top product field bit p[2N] |
| op_a_o | output | N | Current A register |
| op_b_o | output | N | Current B register |
| cost_o | output | CW | Weighted gate-cost total of the current run |

## Verification
Several properties are checked by the bound assertions on every cycle. While done is high, the product equals A·B, the top product bit is clear and the cost equals its closed form. The operand registers hold steady during a run. Adder passes never overlap, and the pass index never leaves its range. The bench scenarios are needed for the rest: the exact latency, the contents of the register after the flip row, the fact that a start pulse in the middle of a run is ignored, and coverage of all 256 operand pairs for N=4. Randomly drawn repeat runs check that a restart clears the state.

// File: rtl/rmul_pkg.sv
package rmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARRAY = 2'd1,
    ST_ADD   = 2'd2,
    ST_DONE  = 2'd3
  } rmul_state_e;
endpackage

// File: rtl/rmul_tof_array.sv
// Row of controlled-controlled flips: tgt[i] ^= ctl & vec[i]
module rmul_tof_array #(
  parameter int N = 4
) (
  input  logic         ctl_i,
  input  logic [N-1:0] vec_i,
  input  logic [N-1:0] tgt_i,
  output logic [N-1:0] tgt_o
);
  for (genvar i = 0; i < N; i++) begin : g_flip
    assign tgt_o[i] = tgt_i[i] ^ (ctl_i & vec_i[i]);
  end
endmodule

// File: rtl/rmul_ctrl_add.sv
// One controlled in-place add pass: when ctrl, win += addend, carry-out
// toggles ext_lo, ext_hi is returned untouched. Result registered.
module rmul_ctrl_add #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic         ctrl_i,
  input  logic [N-1:0] addend_i,
  input  logic [N-1:0] win_i,
  input  logic         ext_lo_i,
  input  logic         ext_hi_i,
  output logic         fin_o,
  output logic [N-1:0] win_o,
  output logic         ext_lo_o,
  output logic         ext_hi_o
);
  logic [N:0]   carry;
  logic [N-1:0] sum;
  logic [N-1:0] win_d;
  logic         lo_d;

  assign carry[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rip
    assign sum[i]     = addend_i[i] ^ win_i[i] ^ carry[i];
    assign carry[i+1] = (addend_i[i] & win_i[i]) |
                        (win_i[i] & carry[i]) |
                        (addend_i[i] & carry[i]);
  end

  always_comb begin
    win_d = win_i;
    lo_d  = ext_lo_i;
    if (ctrl_i) begin
      win_d = sum;
      lo_d  = ext_lo_i ^ carry[N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_o    <= 1'b0;
      win_o    <= '0;
      ext_lo_o <= 1'b0;
      ext_hi_o <= 1'b0;
    end else begin
      fin_o <= go_i;
      if (go_i) begin
        win_o    <= win_d;
        ext_lo_o <= lo_d;
        ext_hi_o <= ext_hi_i;
      end
    end
  end
endmodule

// File: rtl/rev_mul_seq.sv
module rev_mul_seq #(
  parameter int N  = 4,
  parameter int CW = $clog2(21*N*N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [N-1:0]  op_a_i,
  input  logic [N-1:0]  op_b_i,
  output logic          done_o,
  output logic [2*N-1:0] prod_o,
  output logic          spare_o,
  output logic [N-1:0]  op_a_o,
  output logic [N-1:0]  op_b_o,
  output logic [CW-1:0] cost_o
);
  import rmul_pkg::*;

  localparam int PW = 2*N + 1;
  localparam int JW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] TOF_COST = CW'(7*N);
  localparam logic [CW-1:0] ADD_COST = CW'(21*N + 14);
  localparam logic [JW-1:0] J_LAST   = JW'(N - 1);
  localparam logic [PW-1:0] WMASK    = PW'({(N+2){1'b1}});

  rmul_state_e   state_q, state_d;
  logic [N-1:0]  a_q, a_d, b_q, b_d;
  logic [PW-1:0] p_q, p_d;
  logic [JW-1:0] j_q, j_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cost_q, cost_d;

  logic [N-1:0]  tof_out;
  logic [PW-1:0] shifted;
  logic [PW-1:0] merged;
  logic          ad_go, ad_fin, ad_lo, ad_hi;
  logic [N-1:0]  ad_win;

  rmul_tof_array #(.N(N)) u_tof (
    .ctl_i (b_q[0]),
    .vec_i (a_q),
    .tgt_i (p_q[N-1:0]),
    .tgt_o (tof_out)
  );

  assign shifted = p_q >> j_q;
  assign ad_go   = (state_q == ST_ADD) && !busy_q;

  rmul_ctrl_add #(.N(N)) u_add (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (ad_go),
    .ctrl_i   (b_q[j_q]),
    .addend_i (a_q),
    .win_i    (shifted[N-1:0]),
    .ext_lo_i (shifted[N]),
    .ext_hi_i (shifted[N+1]),
    .fin_o    (ad_fin),
    .win_o    (ad_win),
    .ext_lo_o (ad_lo),
    .ext_hi_o (ad_hi)
  );

  assign merged = (p_q & ~(WMASK << j_q)) |
                  (PW'({ad_hi, ad_lo, ad_win}) << j_q);

  always_comb begin
    state_d = state_q;
    a_d     = a_q;
    b_d     = b_q;
    p_d     = p_q;
    j_d     = j_q;
    busy_d  = busy_q;
    cost_d  = cost_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          a_d     = op_a_i;
          b_d     = op_b_i;
          p_d     = '0;
          cost_d  = '0;
          j_d     = '0;
          busy_d  = 1'b0;
          state_d = ST_ARRAY;
        end
      end
      ST_ARRAY: begin
        p_d     = {p_q[PW-1:N], tof_out};
        cost_d  = cost_q + TOF_COST;
        j_d     = JW'(1);
        state_d = (N > 1) ? ST_ADD : ST_DONE;
      end
      ST_ADD: begin
        if (ad_go) begin
          busy_d = 1'b1;
        end
        if (ad_fin) begin
          p_d    = merged;
          cost_d = cost_q + ADD_COST;
          busy_d = 1'b0;
          if (j_q == J_LAST) begin
            state_d = ST_DONE;
          end else begin
            j_d = j_q + JW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      p_q     <= '0;
      j_q     <= '0;
      busy_q  <= 1'b0;
      cost_q  <= '0;
    end else begin
      state_q <= state_d;
      a_q     <= a_d;
      b_q     <= b_d;
      p_q     <= p_d;
      j_q     <= j_d;
      busy_q  <= busy_d;
      cost_q  <= cost_d;
    end
  end

  assign done_o  = (state_q == ST_DONE);
  assign prod_o  = p_q[2*N-1:0];
  assign spare_o = p_q[2*N];
  assign op_a_o  = a_q;
  assign op_b_o  = b_q;
  assign cost_o  = cost_q;
endmodule

// File: rtl/rmul_chk.sv
module rmul_chk #(
  parameter int N  = 4,
  parameter int CW = 9,
  parameter int JW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 done_o,
  input logic [2*N-1:0]       prod_o,
  input logic                 spare_o,
  input logic [N-1:0]         op_a_o,
  input logic [N-1:0]         op_b_o,
  input logic [CW-1:0]        cost_o,
  input rmul_pkg::rmul_state_e state_q,
  input logic [JW-1:0]        j_q,
  input logic                 ad_go,
  input logic                 ad_fin
);
  import rmul_pkg::*;
  localparam logic [CW-1:0] FINAL_COST = CW'(21*N*N - 14);

  // R5
  prod_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> prod_o == ((2*N)'(op_a_o) * (2*N)'(op_b_o)));

  // R6
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !spare_o);

  // R8
  cost_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cost_o == FINAL_COST);

  // R7
  ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADD) |=> $stable(op_a_o) && $stable(op_b_o));

  // R9
  pass_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_go |=> !ad_go && ad_fin);

  // R9
  pass_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADD) |-> (j_q >= JW'(1)) && (j_q <= JW'(N-1)));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(prod_o));
endmodule

bind rev_mul_seq rmul_chk #(
  .N  (N),
  .CW (CW),
  .JW (JW)
) u_rmul_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .done_o  (done_o),
  .prod_o  (prod_o),
  .spare_o (spare_o),
  .op_a_o  (op_a_o),
  .op_b_o  (op_b_o),
  .cost_o  (cost_o),
  .state_q (state_q),
  .j_q     (j_q),
  .ad_go   (ad_go),
  .ad_fin  (ad_fin)
);

// File: tb/test_rev_mul_seq.sv
module test_rev_mul_seq;
  localparam int N  = 4;
  localparam int CW = $clog2(21*N*N + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [N-1:0]   op_a_i = '0;
  logic [N-1:0]   op_b_i = '0;
  logic           done_o;
  logic [2*N-1:0] prod_o;
  logic           spare_o;
  logic [N-1:0]   op_a_o, op_b_o;
  logic [CW-1:0]  cost_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rev_mul_seq #(.N(N)) i_rev_mul_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .done_o(done_o),
    .prod_o(prod_o), .spare_o(spare_o), .op_a_o(op_a_o),
    .op_b_o(op_b_o), .cost_o(cost_o)
  );

  function automatic longint gold_prod(input int a, input int b);
    return longint'(a) * longint'(b);
  endfunction

  function automatic longint gold_cost();
    return 21*N*N - 14;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // intrude: pulse start with other operands mid-run (R10)
  task automatic run_one(input int a, input int b, input bit intrude,
                         input bit look_array);
    int lat = 0;
    op_a_i  = N'(a);
    op_b_i  = N'(b);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      start_i = 1'b0;
      if (look_array && k == 1) begin
        // R3: array row result and its cost
        chk(prod_o == (2*N)'(a & ((b & 1) ? ((1 << N) - 1) : 0)),
            "R3", "array row", prod_o, a & ((b & 1) ? ((1 << N) - 1) : 0));
        chk(cost_o == CW'(7*N), "R3", "array cost", cost_o, 7*N);
      end
      if (intrude && k == 2) begin
        op_a_i  = ~N'(a);
        op_b_i  = ~N'(b);
        start_i = 1'b1;
      end
      if (done_o) begin
        lat = k;
        break;
      end
    end
    start_i = 1'b0;
    chk(lat == 2*N - 1, "R4", "latency", lat, 2*N - 1);
    chk(prod_o == (2*N)'(gold_prod(a, b)), intrude ? "R10" : "R5",
        "product", prod_o, gold_prod(a, b));
    chk(spare_o == 1'b0, "R6", "top bit", spare_o, 0);
    chk(op_a_o == N'(a) && op_b_o == N'(b), "R7", "operands",
        {op_a_o, op_b_o}, {N'(a), N'(b)});
    chk(cost_o == CW'(gold_cost()), "R8", "cost", cost_o, gold_cost());
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(done_o == 0 && prod_o == 0 && spare_o == 0 && cost_o == 0,
        "R1", "reset outputs", {done_o, prod_o, spare_o, cost_o}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(done_o == 0 && cost_o == 0, "R1", "after release",
        {done_o, cost_o}, 0);

    // directed corners, with array-row look
    run_one(0, 0, 1'b0, 1'b1);
    run_one(15, 15, 1'b0, 1'b1);
    run_one(15, 1, 1'b0, 1'b1);
    run_one(9, 14, 1'b0, 1'b1);

    // R10: hold after done
    repeat (4) @(posedge clk);
    #1;
    chk(done_o == 1'b1, "R10", "done held", done_o, 1);
    chk(prod_o == (2*N)'(126), "R10", "product held", prod_o, 126);

    // R10: start ignored mid-run
    run_one(13, 11, 1'b1, 1'b0);
    run_one(15, 15, 1'b1, 1'b0);

    // R2/R5: exhaustive pairs (restart clears state each time)
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run_one(a, b, 1'b0, 1'b0);
      end
    end

    // R2: random restarts from finished state
    for (int r = 0; r < 40; r++) begin
      int ra = int'($urandom() % (1 << N));
      int rb = int'($urandom() % (1 << N));
      run_one(ra, rb, r[0], r[1]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule